// File: doc/BRIEF.md
# Register-Controlled GPIO Port with Peripheral Pin Takeover

This block is a general-purpose I/O port of eight pins by default, programmed over a small register bus with one select, one write strobe and a one-bit offset. The port holds an output-value register and a direction register. From these it drives a registered output enable and a registered output level for every pin. A read at one offset returns the stored output values. A read at the other offset returns the pin levels after a two-flop synchronizer. The direction register cannot be read back, because its offset is shared with the pin-level read.

A takeover input lets an external controller, such as a keyboard-scan engine, own the upper pins (7 down to 2 by default). While takeover is high, those pins take their enable and level from the controller's inputs. The low pins stay under register control. The direction register is left untouched during takeover. Its setting applies again on the first clock after takeover drops.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is held, and on the first clock after reset is released, every output enable and output level is 0. Both registers start at 0x00, and a read at offset 0 returns 0x00.
- R2: When takeover is low, a direction bit of 1 drives that pin's output enable high, and a direction bit of 0 drives it low.
- R3: A write at offset 1 loads the direction register. A read at offset 1 returns the synchronized pin levels and never the direction register.
- R4: A write at offset 0 loads the output-value register. A read at offset 0 returns that stored value whatever the direction bits are. Each register-controlled pin drives its stored value as its output level, even when it is an input.
- R5: When takeover is high, pins 7 down to 2 drive the controller's enable and level inputs. Bit 0 of each controller bus maps to pin 2.
- R6: Pins 1 and 0 follow the two registers whatever the takeover input is.
- R7: A direction write made during takeover is kept. The kept direction setting drives the upper pins from the first clock edge after takeover returns to 0.
- R8: A pin change sampled at one clock edge appears in a read at offset 1 after the second clock edge that follows, and not before.
- R9: A register is written only on a clock edge where select and write are both high. A write strobe without select, or a select without write, changes nothing.
- R10: Output enables and levels are registered. They take the new value on the same clock edge that captures a register write or a change of the takeover inputs, and they hold steady between edges.
- R11: When select is low, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_ofs | input | 1 | Offset: 0 = output values, 1 = direction write / pin-level read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Pin levels from the pads |
| tko_en | input | 1 | Takeover of the upper pins by the external controller |
| tko_oe | input | 6 | Controller output enables for pins 7..2 |
| tko_out | input | 6 | Controller output levels for pins 7..2 |
| pin_oe | output | 8 | Registered output enables |
| pin_out | output | 8 | Registered output levels |

## Verification
The properties assume that select, write strobe, offset, write data, takeover and the controller buses all change away from the rising clock edge and are steady when that edge samples them. They also assume reset is low from time zero, so the takeover and pin-read checks only begin after a few clean cycles. The bench drives every input at the falling edge, whether random or directed, and asserts reset before the first rising edge. The random stream mixes takeover, select and write, so every property's trigger condition comes up many times.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   typedef enum logic {
      OFS_VALUE = 1'b0,
      OFS_DIR   = 1'b1
   } gpio_ofs_e;

   typedef struct packed {
      logic ld_value;
      logic ld_dir;
   } gpio_ld_s;

   function automatic gpio_ld_s gpio_decode(input logic sel, input logic wr, input logic ofs);
      gpio_ld_s r;
      r.ld_value = sel && wr && (gpio_ofs_e'(ofs) == OFS_VALUE);
      r.ld_dir   = sel && wr && (gpio_ofs_e'(ofs) == OFS_DIR);
      return r;
   endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin : p_chk
      assert (STAGES >= 2) else $error("gpio_sync_chain: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("gpio_sync_chain: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= '0;
               else        stg[k] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= '0;
               else        stg[k] <= stg[k-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gpio_ld_s         ld,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] value_q,
   output logic [WIDTH-1:0] value_nxt,
   output logic [WIDTH-1:0] dir_nxt
);

   logic [WIDTH-1:0] dir_q;

   // Next-state values feed both the storage and the pin drivers,
   // so outputs move on the same edge that captures a write.
   always_comb begin
      value_nxt = ld.ld_value ? wdata : value_q;
      dir_nxt   = ld.ld_dir   ? wdata : dir_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
         dir_q   <= '0;
      end else begin
         value_q <= value_nxt;
         dir_q   <= dir_nxt;
      end
   end

endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
   parameter int WIDTH  = 8,
   parameter int OVR_LO = 2,
   localparam int OVR_W = WIDTH - OVR_LO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] dir_nxt,
   input  logic [WIDTH-1:0] value_nxt,
   input  logic             tko_en,
   input  logic [OVR_W-1:0] tko_oe,
   input  logic [OVR_W-1:0] tko_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out
);

   logic [WIDTH-1:0] oe_d;
   logic [WIDTH-1:0] out_d;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_pin
         if (i >= OVR_LO) begin : g_shared
            assign oe_d[i]  = tko_en ? tko_oe[i-OVR_LO]  : dir_nxt[i];
            assign out_d[i] = tko_en ? tko_out[i-OVR_LO] : value_nxt[i];
         end else begin : g_fixed
            assign oe_d[i]  = dir_nxt[i];
            assign out_d[i] = value_nxt[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_oe  <= '0;
         pin_out <= '0;
      end else begin
         pin_oe  <= oe_d;
         pin_out <= out_d;
      end
   end

endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int OVR_LO      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int OVR_W      = WIDTH - OVR_LO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic             bus_ofs,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pin_in,
   input  logic             tko_en,
   input  logic [OVR_W-1:0] tko_oe,
   input  logic [OVR_W-1:0] tko_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out
);

   initial begin : p_chk
      assert (WIDTH >= 2 && WIDTH <= 32) else $error("gpio_port_ovr: WIDTH out of range");
      assert (OVR_LO >= 0 && OVR_LO < WIDTH) else $error("gpio_port_ovr: OVR_LO must lie below WIDTH");
      assert (SYNC_STAGES >= 2) else $error("gpio_port_ovr: SYNC_STAGES must be at least 2");
   end

   gpio_ld_s         ld;
   logic [WIDTH-1:0] value_q;
   logic [WIDTH-1:0] value_nxt;
   logic [WIDTH-1:0] dir_nxt;
   logic [WIDTH-1:0] pin_sync;

   assign ld = gpio_decode(bus_sel, bus_wr, bus_ofs);

   gpio_ctl_regs #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld),
      .wdata     (bus_wdata),
      .value_q   (value_q),
      .value_nxt (value_nxt),
      .dir_nxt   (dir_nxt)
   );

   gpio_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_pin_drv #(.WIDTH(WIDTH), .OVR_LO(OVR_LO)) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_nxt   (dir_nxt),
      .value_nxt (value_nxt),
      .tko_en    (tko_en),
      .tko_oe    (tko_oe),
      .tko_out   (tko_out),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out)
   );

   // Offset 1 reads pin levels; the direction register has no read path.
   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (gpio_ofs_e'(bus_ofs) == OFS_DIR) bus_rdata = pin_sync;
         else                                 bus_rdata = value_q;
      end
   end

endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
   parameter int WIDTH       = 8,
   parameter int OVR_LO      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int OVR_W      = WIDTH - OVR_LO
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             bus_ofs,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pin_in,
   input logic             tko_en,
   input logic [OVR_W-1:0] tko_oe,
   input logic [OVR_W-1:0] tko_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_out
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

   assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_ofs && !tko_en) |=> (pin_oe == $past(bus_wdata)));

   assert_value_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_ofs) ##1 (bus_sel && !bus_wr && !bus_ofs)
      |-> (bus_rdata == $past(bus_wdata)));

   assert_tko_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tko_en |=> (pin_oe[WIDTH-1:OVR_LO] == $past(tko_oe)));

   assert_tko_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tko_en |=> (pin_out[WIDTH-1:OVR_LO] == $past(tko_out)));

   generate
      if (OVR_LO > 0) begin : g_low
         assert_low_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && !bus_ofs) |=> (pin_out[OVR_LO-1:0] == $past(bus_wdata[OVR_LO-1:0])));
         assert_low_oe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && bus_wr && bus_ofs) |=> $stable(pin_oe[OVR_LO-1:0]));
         assert_low_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && bus_wr && !bus_ofs) |=> $stable(pin_out[OVR_LO-1:0]));
      end
      if (SYNC_STAGES == 2) begin : g_sync2
         assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && bus_sel && bus_ofs) |-> (bus_rdata == $past(pin_in, 2)));
      end
   endgenerate

   assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0));

endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(
   .WIDTH(WIDTH), .OVR_LO(OVR_LO), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .tko_en(tko_en),
   .tko_oe(tko_oe), .tko_out(tko_out), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/gpio_port_ovr_tb.sv
`timescale 1ns/1ps
module gpio_port_ovr_tb;
   localparam int W  = 8;
   localparam int LO = 2;
   localparam int OW = W - LO;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_ofs = 1'b0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [W-1:0]  pin_in = '0;
   logic          tko_en = 1'b0;
   logic [OW-1:0] tko_oe = '0, tko_out = '0;
   logic [W-1:0]  pin_oe, pin_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [W-1:0] m_dir = '0, m_val = '0, m_s1 = '0, m_s2 = '0, m_oe = '0, m_out = '0;

   always #2.5 clk = ~clk;

   gpio_port_ovr #(.WIDTH(W), .OVR_LO(LO), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .tko_en(tko_en),
      .tko_oe(tko_oe), .tko_out(tko_out), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endfunction

   function automatic logic [W-1:0] f_oe(input logic [W-1:0] dir, input logic en, input logic [OW-1:0] po);
      logic [W-1:0] r = dir;
      if (en) r[W-1:LO] = po;
      return r;
   endfunction

   function automatic logic [W-1:0] f_out(input logic [W-1:0] val, input logic en, input logic [OW-1:0] pv);
      logic [W-1:0] r = val;
      if (en) r[W-1:LO] = pv;
      return r;
   endfunction

   // One clock: drive at the falling edge, check reads and held outputs,
   // cross the rising edge, update the model, check outputs at the next fall.
   task automatic cyc(input logic s, input logic w, input logic a, input logic [W-1:0] d,
                      input logic [W-1:0] pin, input logic en, input logic [OW-1:0] po,
                      input logic [OW-1:0] pv);
      bus_sel = s; bus_wr = w; bus_ofs = a; bus_wdata = d;
      pin_in = pin; tko_en = en; tko_oe = po; tko_out = pv;
      #1;
      if (s) begin
         if (a) chk("R3 pin-level read", bus_rdata, m_s2);
         else   chk("R4 value read",     bus_rdata, m_val);
      end else   chk("R11 idle read",     bus_rdata, 0);
      chk("R10 oe held between edges", pin_oe, m_oe);
      @(posedge clk);
      if (s && w) begin
         if (a) m_dir = d;
         else   m_val = d;
      end
      m_s2 = m_s1; m_s1 = pin;
      m_oe  = f_oe(m_dir, en, po);
      m_out = f_out(m_val, en, pv);
      @(negedge clk);
      chk("R6 low oe",  pin_oe[LO-1:0],  m_oe[LO-1:0]);
      chk("R6 low out", pin_out[LO-1:0], m_out[LO-1:0]);
      chk(en ? "R5 upper oe"  : "R2 upper oe",  pin_oe[W-1:LO],  m_oe[W-1:LO]);
      chk(en ? "R5 upper out" : "R4 upper out", pin_out[W-1:LO], m_out[W-1:LO]);
   endtask

   initial begin : wd
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      bus_sel = 1'b1; bus_ofs = 1'b0; #1;
      chk("R1 oe in reset",  pin_oe, 0);
      chk("R1 out in reset", pin_out, 0);
      chk("R1 value in reset", bus_rdata, 0);
      bus_sel = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after release",  pin_oe, 0);
      chk("R1 out after release", pin_out, 0);

      // R2 / R4: direction and value, including an input pin driving its value
      cyc(1, 1, 0, 8'h5A, 8'h00, 0, '0, '0);
      chk("R4 out follows value", pin_out, 8'h5A);
      chk("R2 still inputs", pin_oe, 8'h00);
      cyc(1, 1, 1, 8'hC3, 8'h00, 0, '0, '0);
      chk("R2 direction applied", pin_oe, 8'hC3);
      cyc(1, 0, 1, 8'h00, 8'h00, 0, '0, '0);
      chk("R3 read leaves direction", pin_oe, 8'hC3);

      // R9: strobe without select, select without strobe
      cyc(0, 1, 0, 8'hFF, 8'h00, 0, '0, '0);
      cyc(0, 1, 1, 8'h00, 8'h00, 0, '0, '0);
      cyc(1, 0, 0, 8'h00, 8'h00, 0, '0, '0);
      chk("R9 value unchanged", pin_out, 8'h5A);
      chk("R9 direction unchanged", pin_oe, 8'hC3);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = 1'b0; #1;
      chk("R9 value readback", bus_rdata, 8'h5A);

      // R7: takeover keeps the direction write and restores it afterwards
      cyc(1, 0, 0, 8'h00, 8'h00, 1, 6'h00, 6'h3F);
      chk("R5 upper taken over", pin_oe, 8'h03);
      chk("R5 upper level", pin_out, 8'hFE);
      cyc(1, 1, 1, 8'h0F, 8'h00, 1, 6'h00, 6'h3F);
      chk("R7 oe during takeover", pin_oe, 8'h03);
      cyc(0, 0, 0, 8'h00, 8'h00, 0, 6'h00, 6'h00);
      chk("R7 direction restored", pin_oe, 8'h0F);
      chk("R7 value restored", pin_out, 8'h5A);

      // R8: pin change seen after exactly two edges
      cyc(1, 0, 1, 8'h00, 8'hA5, 0, '0, '0);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = 1'b1; #1;
      chk("R8 not after one edge", bus_rdata, 8'h00);
      cyc(1, 0, 1, 8'h00, 8'hA5, 0, '0, '0);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = 1'b1; #1;
      chk("R8 visible after two edges", bus_rdata, 8'hA5);

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic s, w, a, en;
         s  = ($urandom % 4) != 0;
         w  = $urandom % 2;
         a  = $urandom % 2;
         en = ($urandom % 4) == 0;
         cyc(s, w, a, W'($urandom), W'($urandom), en, OW'($urandom), OW'($urandom));
      end

      bus_sel = 1'b0; bus_wr = 1'b0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule